// File: doc/BRIEF.md
# Prescaled Interval/Match Timer Channel

This block is a single 16-bit timer channel. A power-of-two prescaler divides the peripheral clock, or the prescaler is bypassed. The counter steps up or down. It wraps either over the full 16-bit range or over a programmable period, and each wrap raises its own sticky flag. Three compare values are checked against the counter value as it advances. A hit on any of them raises its own sticky flag. One level interrupt output is active while any flag is set and enabled.

All configuration arrives as plain control fields, which would normally be driven by a register bank outside this block. Software-side actions arrive as two single-cycle pulses: one zeroes the counter, and the other clears the flags. The block outputs the live count, the flag vector and the interrupt.

Top module: `prescaled_match_timer`

## Requirements
- R1: While `rst_n` is low, `count`, `flags` and `irq` are all zero.
- R2: `clk_ctrl` bit 0 enables the prescaler and bits 4:1 hold a value N. With the prescaler enabled, the counter moves once every 2^(N+1) clock cycles, counted from the last counter-reset pulse. With it disabled, the counter moves on every clock.
- R3: With `cnt_ctrl` bit 1 set (interval mode) and bit 2 clear, the counter runs 0, 1, ..., `period_val` and then returns to 0. That return sets flag bit 0.
- R4: With `cnt_ctrl` bits 1 and 2 both clear, the counter runs up to 16'hFFFF and then returns to 0. That return sets flag bit 4 and leaves flag bit 0 clear.
- R5: With `cnt_ctrl` bit 2 set, the counter counts down. Stepping from 0 reloads `period_val` in interval mode, or 16'hFFFF otherwise. The reload sets the same flag bit as the upward wrap in that mode.
- R6: When `cnt_ctrl` bit 3 is set and the counter steps onto the value of compare i, flag bit i is set. Compare 1 is `match_val[15:0]`, compare 2 is `match_val[31:16]` and compare 3 is `match_val[47:32]`. In interval mode, a compare value above `period_val` never sets its flag. With bit 3 clear, no compare flag is set.
- R7: With `cnt_ctrl` bit 0 set, the count and the prescaler phase both hold, and no flag is raised.
- R8: A `cnt_rst` pulse sets the count to 0 and restarts the prescaler phase at the next clock edge. This happens whether or not the channel is stopped.
- R9: Flags are sticky. A `flag_clr` pulse clears them at the next edge, but a flag whose event occurs in that same cycle stays set.
- R10: `irq` is high in the same cycle as any bit of `flags & irq_mask` is set. Flag bit 5 is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ctrl | input | 5 | Bit 0 enables the prescaler, bits 4:1 select N |
| cnt_ctrl | input | 4 | Bit 0 stop, bit 1 interval mode, bit 2 count down, bit 3 compare enable |
| period_val | input | 16 | Top count in interval mode |
| match_val | input | 48 | Three 16-bit compare values, compare 1 in the low bits |
| irq_mask | input | 6 | Per-flag interrupt enable |
| cnt_rst | input | 1 | Pulse that zeroes the count and the prescaler phase |
| flag_clr | input | 1 | Pulse that clears the sticky flags |
| count | output | 16 | Live counter value |
| flags | output | 6 | Sticky event flags |
| irq | output | 1 | Level interrupt |

## Verification
The bench checks the exact wrap points. In interval mode the wrap must come after the period value is reached, not on it, and the full-range wrap must come only after 65536 steps. An off-by-one in either place moves the wrap flag one step early or late. The bench also gives a compare value above the period: a design that fails to gate it would raise that flag, and it gives a compare value of 0, which must fire on the wrap itself. Two further cases cover the prescaler phase held across a stop, which a wrong design would let drift and so step the counter early, and a clear pulse in the same cycle as a wrap, which a design with the wrong priority would use to drop the new flag.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  // counter control bit positions
  localparam int C_STOP = 0;
  localparam int C_INTV = 1;
  localparam int C_DOWN = 2;
  localparam int C_MEN  = 3;
  localparam int CC_W   = 4;
  // flag positions (compare flags occupy 1..NM)
  localparam int F_INTV = 0;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
  parameter int PS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_ps,
  input  logic [PS_W-1:0] ps_sel,
  input  logic            run,
  input  logic            zap,
  output logic            tick
);
  localparam int PC_W = 1 << PS_W;

  logic [PC_W-1:0] phase;
  logic [PC_W-1:0] last;

  // last phase value of a 2^(n+1) cycle period
  function automatic logic [PC_W-1:0] term_of(input logic [PS_W-1:0] n);
    logic [PC_W:0] span;
    span = {{PC_W{1'b0}}, 1'b1} << (int'(n) + 1);
    return PC_W'(span - 1'b1);
  endfunction

  assign last = term_of(ps_sel);
  assign tick = run && !zap && (!en_ps || phase == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (zap)        phase <= '0;
    else if (!run)       phase <= phase;
    else if (!en_ps)     phase <= '0;
    else if (phase == last) phase <= '0;
    else                 phase <= phase + 1'b1;
  end

  // R7
  ps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !zap) |=> $stable(phase));
  // R8
  ps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zap |=> (phase == '0));
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             zap,
  input  logic             intv_mode,
  input  logic             down,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] nxt,
  output logic             wrap
);
  logic [CNT_W-1:0] top;
  logic             at_end;

  // returns {wrap, next value}
  function automatic logic [CNT_W:0] step_of(input logic [CNT_W-1:0] cur,
                                             input logic [CNT_W-1:0] lim,
                                             input logic dn);
    if (!dn) begin
      if (cur >= lim) return {1'b1, {CNT_W{1'b0}}};
      return {1'b0, cur + 1'b1};
    end
    if (cur == '0) return {1'b1, lim};
    return {1'b0, cur - 1'b1};
  endfunction

  assign top          = intv_mode ? period : {CNT_W{1'b1}};
  assign {at_end, nxt} = step_of(count, top, down);
  assign wrap         = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (zap)  count <= '0;
    else if (tick) count <= nxt;
  end

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !down && count >= top) |=> (count == '0));
  // R5
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && down && count == '0) |=> (count == $past(top)));
  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !zap) |=> $stable(count));
  // R8
  cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zap |=> (count == '0));
endmodule

// File: rtl/pmt_match.sv
module pmt_match #(
  parameter int CNT_W = 16,
  parameter int NM    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                men,
  input  logic                intv_mode,
  input  logic [CNT_W-1:0]    period,
  input  logic [CNT_W-1:0]    nxt,
  input  logic [NM*CNT_W-1:0] cmp_flat,
  output logic [NM-1:0]       hit
);
  for (genvar i = 0; i < NM; i++) begin : g_cmp
    logic [CNT_W-1:0] cv;
    logic             reach;
    assign cv    = cmp_flat[i*CNT_W +: CNT_W];
    assign reach = !intv_mode || (cv <= period);
    assign hit[i] = tick && men && reach && (nxt == cv);
  end

  // R6
  match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!men || !tick) |-> (hit == '0));
endmodule

// File: rtl/pmt_flags.sv
module pmt_flags #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [FW-1:0] events,
  input  logic [FW-1:0] mask,
  output logic [FW-1:0] flags,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | events;
  end

  assign irq = |(flags & mask);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
  // R9
  new_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(events)) == $past(events)));
  // R10
  rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[FW-1]);
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 4,
  parameter int NM    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PS_W:0]       clk_ctrl,
  input  logic [3:0]          cnt_ctrl,
  input  logic [CNT_W-1:0]    period_val,
  input  logic [NM*CNT_W-1:0] match_val,
  input  logic [NM+2:0]       irq_mask,
  input  logic                cnt_rst,
  input  logic                flag_clr,
  output logic [CNT_W-1:0]    count,
  output logic [NM+2:0]       flags,
  output logic                irq
);
  import pmt_pkg::*;

  localparam int FW    = NM + 3;
  localparam int F_OVF = NM + 1;

  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] nxt;
  logic [NM-1:0]    hit;
  logic [FW-1:0]    events;
  logic             intv;

  assign intv = cnt_ctrl[C_INTV];

  pmt_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n),
    .en_ps(clk_ctrl[0]), .ps_sel(clk_ctrl[PS_W:1]),
    .run(!cnt_ctrl[C_STOP]), .zap(cnt_rst), .tick(tick)
  );

  pmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .zap(cnt_rst),
    .intv_mode(intv), .down(cnt_ctrl[C_DOWN]), .period(period_val),
    .count(count), .nxt(nxt), .wrap(wrap)
  );

  pmt_match #(.CNT_W(CNT_W), .NM(NM)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick), .men(cnt_ctrl[C_MEN]),
    .intv_mode(intv), .period(period_val), .nxt(nxt),
    .cmp_flat(match_val), .hit(hit)
  );

  always_comb begin
    events           = '0;
    events[F_INTV]   = wrap && intv;
    events[F_OVF]    = wrap && !intv;
    events[NM:1]     = hit;
  end

  pmt_flags #(.FW(FW)) u_flags (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr), .events(events),
    .mask(irq_mask), .flags(flags), .irq(irq)
  );

  // R4
  ovf_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !intv) |=> flags[F_OVF]);
endmodule

// File: tb/sim_prescaled_match_timer.sv
`timescale 1ns/1ps
module sim_prescaled_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  clk_ctrl = '0;
  logic [3:0]  cnt_ctrl = 4'b0001;
  logic [15:0] period_val = '0;
  logic [47:0] match_val = '0;
  logic [5:0]  irq_mask = '0;
  logic        cnt_rst = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] count;
  logic [5:0]  flags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prescaled_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .clk_ctrl(clk_ctrl), .cnt_ctrl(cnt_ctrl),
    .period_val(period_val), .match_val(match_val), .irq_mask(irq_mask),
    .cnt_rst(cnt_rst), .flag_clr(flag_clr),
    .count(count), .flags(flags), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // stop, zero the counter and prescaler, clear flags
  task automatic setup();
    cnt_ctrl = 4'b0001;
    clk_ctrl = '0;
    irq_mask = '0;
    cnt_rst  = 1'b1;
    step(1);
    cnt_rst  = 1'b0;
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", count, 0);
    check("R1 flags", flags, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_interval_up();
    setup();
    period_val = 16'd4;
    cnt_ctrl = 4'b0010;
    step(4);
    check("R3 count at top", count, 4);
    check("R3 no flag before wrap", flags, 0);
    step(1);
    check("R3 wrap to zero", count, 0);
    check("R3 interval flag", flags, 6'b000001);
  endtask

  task automatic t_match();
    setup();
    period_val = 16'd9;
    match_val = {16'd0, 16'd12, 16'd3};
    cnt_ctrl = 4'b1010;
    step(2);
    check("R6 no early match", flags, 0);
    step(1);
    check("R6 compare 1 flag", flags, 6'b000010);
    step(22);
    check("R6 compare 3 at zero, compare 2 above period silent", flags, 6'b001011);
    setup();
    cnt_ctrl = 4'b0010;
    step(12);
    check("R6 compare disabled", flags, 6'b000001);
  endtask

  task automatic t_overflow_up();
    setup();
    cnt_ctrl = 4'b0000;
    step(65535);
    check("R4 count at max", count, 16'hFFFF);
    check("R4 no flag yet", flags, 0);
    step(1);
    check("R4 wrap to zero", count, 0);
    check("R4 overflow flag", flags, 6'b010000);
    check("R10 irq masked", irq, 0);
    irq_mask = 6'b010000;
    #1;
    check("R10 irq enabled", irq, 1);
    irq_mask = 6'b000001;
    #1;
    check("R10 irq other bit", irq, 0);
  endtask

  task automatic t_down();
    setup();
    cnt_ctrl = 4'b0100;
    step(1);
    check("R5 full reload", count, 16'hFFFF);
    check("R5 overflow flag", flags, 6'b010000);
    setup();
    period_val = 16'd4;
    cnt_ctrl = 4'b0110;
    step(1);
    check("R5 interval reload", count, 4);
    check("R5 interval flag", flags, 6'b000001);
    step(4);
    check("R5 down to zero", count, 0);
  endtask

  task automatic t_clear();
    setup();
    period_val = 16'd4;
    cnt_ctrl = 4'b0110;
    step(1);
    cnt_ctrl = 4'b0111;
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check("R9 sticky through plain clear", flags, 0);
    cnt_ctrl = 4'b0110;
    step(4);
    check("R9 sticky after wrap", count, 0);
    flag_clr = 1'b1;
    step(1);
    flag_clr = 1'b0;
    check("R9 event beats clear", flags, 6'b000001);
    check("R10 reserved flag", flags[5], 0);
  endtask

  task automatic t_prescale();
    setup();
    clk_ctrl = {4'd2, 1'b1};
    cnt_ctrl = 4'b0000;
    step(7);
    check("R2 div8 before", count, 0);
    step(1);
    check("R2 div8 first step", count, 1);
    step(8);
    check("R2 div8 second step", count, 2);
  endtask

  task automatic t_stop();
    setup();
    clk_ctrl = {4'd1, 1'b1};
    cnt_ctrl = 4'b0000;
    step(2);
    cnt_ctrl = 4'b0001;
    step(5);
    cnt_ctrl = 4'b0000;
    step(1);
    check("R7 prescaler phase held", count, 0);
    step(1);
    check("R7 step after resume", count, 1);
    setup();
    period_val = 16'd100;
    cnt_ctrl = 4'b0010;
    step(5);
    cnt_ctrl = 4'b0011;
    step(10);
    check("R7 count held", count, 5);
    check("R7 no flags while stopped", flags, 0);
    cnt_rst = 1'b1;
    step(1);
    cnt_rst = 1'b0;
    check("R8 reset while stopped", count, 0);
    cnt_ctrl = 4'b0010;
    step(7);
    cnt_rst = 1'b1;
    step(1);
    cnt_rst = 1'b0;
    check("R8 reset while running", count, 0);
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_interval_up();
    t_match();
    t_overflow_up();
    t_down();
    t_clear();
    t_prescale();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20ns * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule